// File: doc/BRIEF.md
# Prioritized Interrupt Request and Service Tracker

This block keeps the interrupt state of one processor. A 256-bit request vector records interrupts that have been raised but not yet taken. A 256-bit in-service vector records interrupts that the core has accepted but not yet finished. An 8-bit task priority value and a derived processor priority value decide which request may be delivered next. Each cycle the block shows the best deliverable vector, if there is one. The core answers with an accept, and later with an end-of-interrupt.

Accepted vectors go onto a nesting stack of parameterized depth. The vector on top of that stack sets the processor priority. A three-state machine follows how full the stack is:
- `S_EMPTY`: nothing is in service.
- `S_NESTED`: at least one entry, room left.
- `S_FULL`: stack depth reached.

The transitions are:
- `S_EMPTY` to `S_NESTED` on an accept.
- `S_NESTED` to `S_FULL` on the accept that fills the last slot.
- `S_NESTED` to `S_EMPTY` on the end-of-interrupt that removes the last entry.
- `S_FULL` to `S_NESTED` on an end-of-interrupt.

Every other combination keeps the current state. All register updates take effect on the clock edge where the command is sampled.

Top module: `irq_prio_tracker`

## Requirements
- R1: The class of a vector is bits [7:4]. `pend_valid` is high only when the highest set request bit in 32..255 has a class strictly greater than the class of `ppr_q`. `pend_vec` is then that vector. In every other case `pend_valid` is low.
- R2: Vectors 0 to 31 may be recorded in `irr_q`, but they are never reported as pending. End-of-interrupt never clears them.
- R3: `ppr_q` equals `tpr_q` when the class of `tpr_q` is at least the class of the top stack vector. Otherwise `ppr_q` is the top vector with bits [3:0] cleared. An empty stack counts as a top vector of 0.
- R4: An accept of `ack_vec` does the following, all visible after the next edge:
  - clears its request bit;
  - sets its in-service bit;
  - pushes it on the stack;
  - recomputes `ppr_q`.
- R5: An end-of-interrupt with something in service clears the highest set in-service bit in 32..255, pops the stack and recomputes `ppr_q`. With nothing in service it changes nothing.
- R6: A write of the task priority keeps only `tpr_wdata[7:0]` and recomputes `ppr_q` in the same edge.
- R7: `req_valid` sets request bit `req_vec` at the next edge. If the same vector is requested and accepted in one cycle, the request bit ends up set.
- R8: An accept while the stack holds `STK_DEPTH` entries is dropped: request bits, in-service bits and stack stay unchanged, and `err` is raised.
- R9: An accept while the stack is not empty, whose class is not strictly greater than the class of the top entry, is still performed and raises `err`.
- R10: When `eoi` and `ack_valid` are high in the same cycle, only the end-of-interrupt is performed.
- R11: After reset the following are all zero: `irr_q`, `isr_q`, `tpr_q`, `ppr_q`, `err` and `pend_valid`. `err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Raise request for `req_vec` |
| req_vec | input | 8 | Requested vector |
| ack_valid | input | 1 | Core accepts `ack_vec` |
| ack_vec | input | 8 | Accepted vector |
| eoi | input | 1 | End of interrupt |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_wdata | input | 32 | Task priority write data (low 8 bits kept) |
| pend_valid | output | 1 | A deliverable vector exists |
| pend_vec | output | 8 | Highest deliverable vector |
| irr_q | output | 256 | Request bits |
| isr_q | output | 256 | In-service bits |
| tpr_q | output | 8 | Task priority |
| ppr_q | output | 8 | Processor priority |
| err | output | 1 | Sticky overflow / nesting-order error |

## Verification
The bench checks the following corner cases:
- **Class-equal request.** A request in the same class as the processor priority must stay hidden. A strict-versus-non-strict comparison slip would deliver it early.
- **Reserved vector.** A request for a vector below 32 must never surface. Scanning the whole register would report it.
- **Upper TPR bits.** A task priority write with nonzero upper bits must keep only the low byte. A wider register would corrupt the processor priority.
- **Highest bit versus stack top.** End-of-interrupt is checked after an out-of-order nesting, where the highest in-service bit is not the stack top. A design that cleared the stack top would leave the wrong bit set.
- **Full stack.** An accept into a full stack must be dropped.
- **Same-vector request and accept.** A simultaneous request and accept of one vector must leave the request bit set.
- **Accept during end-of-interrupt.** An accept that coincides with an end-of-interrupt must not be applied. A design that performed it would push a phantom nesting level.

// File: rtl/irqt_pkg.sv
package irqt_pkg;
    localparam int VEC_W   = 8;
    localparam int NVEC    = 1 << VEC_W;
    localparam int FIRST_OK = 32;
    localparam int CLS_W   = 4;

    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [CLS_W-1:0] cls_t;

    typedef enum logic [1:0] {
        S_EMPTY  = 2'd0,
        S_NESTED = 2'd1,
        S_FULL   = 2'd2
    } nest_state_e;

    function automatic cls_t vclass(input vec_t v);
        return v[VEC_W-1 -: CLS_W];
    endfunction
endpackage

// File: rtl/irqt_pick_highest.sv
module irqt_pick_highest #(
    parameter int N  = 256,
    parameter int LO = 32,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  bits,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Ascending scan: the last set bit seen is the highest one.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = LO; i < N; i++) begin
            if (bits[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irqt_nest_stack.sv
module irqt_nest_stack
    import irqt_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  vec_t          push_vec,
    output vec_t          top,
    output vec_t          below,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    vec_t          slot [DEPTH];
    logic [CW-1:0] cnt;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot[g] <= '0;
                else if (push && cnt == CW'(g))
                    slot[g] <= push_vec;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (push && cnt != CW'(DEPTH))
            cnt <= cnt + 1'b1;
        else if (pop && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Empty stack reads as the placeholder vector 0.
    always_comb begin
        top   = '0;
        below = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt == CW'(i + 1)) top   = slot[i];
            if (cnt == CW'(i + 2)) below = slot[i];
        end
    end

    assign count = cnt;
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));

    p_push_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (count == $past(count) + 1'b1));
    p_pop_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/irq_prio_tracker.sv
module irq_prio_tracker
    import irqt_pkg::*;
#(
    parameter int STK_DEPTH = 16,
    localparam int CW = $clog2(STK_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [7:0]       req_vec,
    input  logic             ack_valid,
    input  logic [7:0]       ack_vec,
    input  logic             eoi,
    input  logic             tpr_wr,
    input  logic [31:0]      tpr_wdata,
    output logic             pend_valid,
    output logic [7:0]       pend_vec,
    output logic [NVEC-1:0]  irr_q,
    output logic [NVEC-1:0]  isr_q,
    output logic [7:0]       tpr_q,
    output logic [7:0]       ppr_q,
    output logic             err
);
    nest_state_e   state, state_d;
    vec_t          stk_top, stk_below;
    logic [CW-1:0] stk_cnt;
    logic          stk_empty, stk_full;

    logic          irr_hit, isr_hit;
    vec_t          irr_idx, isr_idx;

    logic          do_eoi, do_acc, ovf, cls_bad;
    logic [NVEC-1:0] req_mask, acc_mask, eoi_mask;
    vec_t          tpr_d, top_d, ppr_d;

    // Command decode: end-of-interrupt wins over accept.
    always_comb begin
        do_eoi  = eoi && (state != S_EMPTY);
        do_acc  = ack_valid && !eoi && (state != S_FULL);
        ovf     = ack_valid && !eoi && (state == S_FULL);
        cls_bad = do_acc && (state != S_EMPTY) && (vclass(ack_vec) <= vclass(stk_top));
    end

    always_comb begin
        req_mask = req_valid ? (NVEC'(1) << req_vec) : '0;
        acc_mask = do_acc ? (NVEC'(1) << ack_vec) : '0;
        eoi_mask = (do_eoi && isr_hit) ? (NVEC'(1) << isr_idx) : '0;
    end

    irqt_pick_highest #(.N(NVEC), .LO(FIRST_OK)) u_irr_pick (
        .bits(irr_q), .hit(irr_hit), .idx(irr_idx)
    );
    irqt_pick_highest #(.N(NVEC), .LO(FIRST_OK)) u_isr_pick (
        .bits(isr_q), .hit(isr_hit), .idx(isr_idx)
    );

    irqt_nest_stack #(.DEPTH(STK_DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n),
        .push(do_acc), .pop(do_eoi), .push_vec(ack_vec),
        .top(stk_top), .below(stk_below), .count(stk_cnt),
        .empty(stk_empty), .full(stk_full)
    );

    // Nesting state machine: next state
    always_comb begin
        state_d = state;
        unique case (state)
            S_EMPTY: begin
                if (do_acc) state_d = (STK_DEPTH == 1) ? S_FULL : S_NESTED;
            end
            S_NESTED: begin
                if (do_acc && stk_cnt == CW'(STK_DEPTH - 1)) state_d = S_FULL;
                else if (do_eoi && stk_cnt == CW'(1))        state_d = S_EMPTY;
            end
            S_FULL: begin
                if (do_eoi) state_d = (STK_DEPTH == 1) ? S_EMPTY : S_NESTED;
            end
            default: state_d = S_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_EMPTY;
        else        state <= state_d;
    end

    // Priority recomputation from the post-update task priority and stack top
    always_comb begin
        tpr_d = tpr_wr ? tpr_wdata[7:0] : tpr_q;
        if (do_acc)      top_d = ack_vec;
        else if (do_eoi) top_d = stk_below;
        else             top_d = stk_top;
        if (vclass(tpr_d) >= vclass(top_d)) ppr_d = tpr_d;
        else                                ppr_d = {vclass(top_d), 4'h0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            tpr_q <= '0;
            ppr_q <= '0;
            err   <= 1'b0;
        end else begin
            irr_q <= (irr_q & ~acc_mask) | req_mask;
            isr_q <= (isr_q | acc_mask) & ~eoi_mask;
            tpr_q <= tpr_d;
            ppr_q <= ppr_d;
            err   <= err | ovf | cls_bad;
        end
    end

    // Output process: deliverable vector
    always_comb begin
        pend_vec   = irr_idx;
        pend_valid = irr_hit && (vclass(irr_idx) > vclass(ppr_q));
    end

    p_fsm_tracks_stack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_EMPTY) == stk_empty) && ((state == S_FULL) == stk_full));
    p_pend_above_ppr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (pend_vec[7:4] > ppr_q[7:4]));
    p_pend_not_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (pend_vec >= 8'(FIRST_OK)));
    p_ppr_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ppr_q == tpr_q) || (ppr_q[3:0] == 4'h0 && ppr_q[7:4] > tpr_q[7:4]));
    p_eoi_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && state == S_EMPTY && !ack_valid) |=> $stable(isr_q));
    p_tpr_low_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tpr_wr |=> (tpr_q == $past(tpr_wdata[7:0])));
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !eoi && state == S_FULL) |=> (err && $stable(isr_q)));
endmodule

// File: tb/irq_prio_tracker_test.sv
module irq_prio_tracker_test;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, ack_valid = 1'b0, eoi = 1'b0, tpr_wr = 1'b0;
    logic [7:0] req_vec = '0, ack_vec = '0;
    logic [31:0] tpr_wdata = '0;
    logic pend_valid, err;
    logic [7:0] pend_vec, tpr_q, ppr_q;
    logic [255:0] irr_q, isr_q;

    always #2.5 clk = ~clk;

    irq_prio_tracker #(.STK_DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vec(req_vec),
        .ack_valid(ack_valid), .ack_vec(ack_vec),
        .eoi(eoi), .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata),
        .pend_valid(pend_valid), .pend_vec(pend_vec),
        .irr_q(irr_q), .isr_q(isr_q), .tpr_q(tpr_q), .ppr_q(ppr_q), .err(err)
    );

    typedef struct {
        string        tag;
        int           kind;
        logic [255:0] val;
    } exp_t;

    exp_t exp_q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    // Reference model
    logic [255:0] m_irr, m_isr;
    logic [7:0]   m_tpr, m_ppr;
    logic         m_err;
    logic [7:0]   m_stk[$];

    function automatic logic [7:0] m_top();
        return (m_stk.size() == 0) ? 8'h00 : m_stk[$];
    endfunction

    task automatic m_reset();
        m_irr = '0; m_isr = '0; m_tpr = '0; m_ppr = '0; m_err = 0;
        m_stk.delete();
    endtask

    task automatic m_ppr_update();
        logic [7:0] t;
        t = m_top();
        m_ppr = (m_tpr[7:4] >= t[7:4]) ? m_tpr : {t[7:4], 4'h0};
    endtask

    task automatic push_all(string tag);
        exp_t e;
        logic pv;
        logic [7:0] pvec;
        pv = 0; pvec = 0;
        for (int v = 255; v >= 32; v--) begin
            if (m_irr[v]) begin
                pvec = 8'(v);
                pv = (pvec[7:4] > m_ppr[7:4]);
                break;
            end
        end
        e.tag = tag;
        e.kind = 0; e.val = m_irr;          exp_q.push_back(e);
        e.kind = 1; e.val = m_isr;          exp_q.push_back(e);
        e.kind = 2; e.val = 256'(m_tpr);    exp_q.push_back(e);
        e.kind = 3; e.val = 256'(m_ppr);    exp_q.push_back(e);
        e.kind = 4; e.val = 256'(pv);       exp_q.push_back(e);
        if (pv) begin
            e.kind = 5; e.val = 256'(pvec); exp_q.push_back(e);
        end
        e.kind = 6; e.val = 256'(m_err);    exp_q.push_back(e);
    endtask

    // Driver: one cycle of stimulus, model update, expectations queued
    task automatic step(string tag, bit rv, logic [7:0] rvec, bit av, logic [7:0] avec,
                        bit e, bit tw, logic [31:0] twd);
        @(negedge clk);
        req_valid = rv; req_vec = rvec; ack_valid = av; ack_vec = avec;
        eoi = e; tpr_wr = tw; tpr_wdata = twd;
        @(posedge clk);
        #1;
        req_valid = 0; ack_valid = 0; eoi = 0; tpr_wr = 0;
        if (e) begin
            if (m_stk.size() != 0) begin
                for (int v = 255; v >= 32; v--) begin
                    if (m_isr[v]) begin m_isr[v] = 1'b0; break; end
                end
                void'(m_stk.pop_back());
            end
        end else if (av) begin
            if (m_stk.size() == DEPTH) m_err = 1;
            else begin
                if (m_stk.size() != 0 && avec[7:4] <= m_top() >> 4) m_err = 1;
                m_irr[avec] = 1'b0;
                m_isr[avec] = 1'b1;
                m_stk.push_back(avec);
            end
        end
        if (rv) m_irr[rvec] = 1'b1;
        if (tw) m_tpr = twd[7:0];
        m_ppr_update();
        push_all(tag);
    endtask

    task automatic do_reset(string tag);
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1;
        m_reset();
        push_all(tag);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    // Monitor: compare queued expectations against the outputs
    always @(negedge clk) begin
        while (exp_q.size() != 0) begin
            exp_t e;
            logic [255:0] act;
            e = exp_q.pop_front();
            case (e.kind)
                0: act = irr_q;
                1: act = isr_q;
                2: act = 256'(tpr_q);
                3: act = 256'(ppr_q);
                4: act = 256'(pend_valid);
                5: act = 256'(pend_vec);
                default: act = 256'(err);
            endcase
            total++;
            if (act !== e.val) begin
                bad++;
                $display("FAIL %s field=%0d actual=%h expected=%h", e.tag, e.kind, act, e.val);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset("R11 reset state");
        step("R7 R1 request 0x45 pending", 1, 8'h45, 0, 0, 0, 0, 0);
        step("R2 reserved request 0x10", 1, 8'h10, 0, 0, 0, 0, 0);
        step("R6 R3 tpr write upper bits", 0, 0, 0, 0, 0, 1, 32'h1234_5650);
        step("R1 tpr lowered", 0, 0, 0, 0, 0, 1, 32'h0000_0030);
        step("R4 accept 0x45", 0, 0, 1, 8'h45, 0, 0, 0);
        step("R1 same class hidden", 1, 8'h47, 0, 0, 0, 0, 0);
        step("R1 higher class request", 1, 8'h90, 0, 0, 0, 0, 0);
        step("R4 R3 accept 0x90", 0, 0, 1, 8'h90, 0, 0, 0);
        step("R9 out-of-order accept", 0, 0, 1, 8'h47, 0, 0, 0);
        step("R5 eoi clears highest bit", 0, 0, 0, 0, 1, 0, 0);
        step("R5 eoi again", 0, 0, 0, 0, 1, 0, 0);
        step("R5 eoi last", 0, 0, 0, 0, 1, 0, 0);
        step("R5 eoi with none in service", 0, 0, 0, 0, 1, 0, 0);

        do_reset("R11 second reset");
        step("R2 reserved only", 1, 8'h1F, 0, 0, 0, 0, 0);
        step("R7 request and accept same vector", 1, 8'h60, 1, 8'h60, 0, 0, 0);
        step("R10 eoi beats accept", 0, 0, 1, 8'h80, 1, 0, 0);
        step("R5 empty eoi with accept", 0, 0, 1, 8'h70, 1, 0, 0);
        step("R3 tpr above stack", 0, 0, 0, 0, 0, 1, 32'h0000_00A7);

        do_reset("R11 third reset");
        for (int k = 2; k < 16; k++)
            step("R4 fill stack", 0, 0, 1, 8'(k * 16), 0, 0, 0);
        step("R9 fill equal class", 0, 0, 1, 8'hF1, 0, 0, 0);
        step("R9 fill equal class", 0, 0, 1, 8'hF2, 0, 0, 0);
        step("R8 request before overflow", 1, 8'hF5, 0, 0, 0, 0, 0);
        step("R8 accept on full stack dropped", 0, 0, 1, 8'hF5, 0, 0, 0);
        step("R5 eoi from full", 0, 0, 0, 0, 1, 0, 0);
        step("R4 accept after space freed", 0, 0, 1, 8'hF5, 0, 0, 0);

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule